// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes 32-bit command frames from a three-wire serial link: an active-low frame select line, a serial clock and a serial data line. A fast system clock oversamples all three pins, so the block has no logic on the serial clock domain. While the frame select is low, one data bit is taken on every falling edge of the serial clock, most significant bit first. A frame counts only when its 32nd falling edge arrives while the select is still low. At that point the command, address and 12-bit code fields are registered and a one-cycle strobe is raised. A frame whose select rises early is thrown away. In that case a one-cycle drop pulse is raised and the outputs keep their values.

The control path is a three-state machine.

States:
- `ST_IDLE`: no frame is open.
- `ST_SHIFT`: bits are being collected.
- `ST_HELD`: the frame has been committed and the block waits for the select to return high.

Transitions:
- `ST_IDLE` to `ST_SHIFT`: taken on a falling select edge. The shift register and the bit counter are cleared.
- `ST_SHIFT` to `ST_SHIFT`: taken on each falling serial clock edge before the last one. One bit is shifted in.
- `ST_SHIFT` to `ST_HELD`: taken on the 32nd falling edge. The frame is committed.
- `ST_SHIFT` to `ST_IDLE`: taken when the select rises early. The frame is aborted and the shift register is cleared.
- `ST_HELD` to `ST_IDLE`: taken when the select rises. There is no pulse.

Top module: `serial_cmd_rx`

## Requirements
- R1: In the 32-bit frame (bit 31 sent first), bits 27:24 appear on `cmd_op`, bits 23:20 on `cmd_addr` and bits 19:8 on `cmd_code`. Bits 31:28 and 7:0 have no effect on any output.
- R2: A data bit is taken only on a falling serial clock edge. The level of the data line around a rising edge does not affect the result.
- R3: On the 32nd falling serial clock edge of a frame, `cmd_strobe` is high for exactly one system clock cycle. That cycle is the third system clock edge after the pin edge.
- R4: If the select rises after 0 to 31 falling edges, the frame is dropped. `cmd_drop` pulses for one cycle, `cmd_strobe` stays low, and `cmd_op`, `cmd_addr` and `cmd_code` keep their values.
- R5: A dropped frame leaves nothing behind, so the next complete frame decodes exactly as sent.
- R6: Falling serial clock edges after the 32nd are ignored until the select rises. At most one commit occurs per select-low period, and the select rising after a commit raises no `cmd_drop`.
- R7: A frame starts only on a falling edge of the select. Serial clock and data activity while the select is high produces no strobe, no drop and no change of any field.
- R8: Synchronous active-high `rst` sets `cmd_op`, `cmd_addr` and `cmd_code` to zero and holds `cmd_strobe` and `cmd_drop` low.
- R9: `cmd_op`, `cmd_addr` and `cmd_code` change only in a cycle where `cmd_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Frame select, active low |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat | input | 1 | Serial data, MSB first |
| cmd_op | output | 4 | Command field of the last committed frame |
| cmd_addr | output | 4 | Address field of the last committed frame |
| cmd_code | output | 12 | Data code of the last committed frame |
| cmd_strobe | output | 1 | One-cycle pulse when a frame commits |
| cmd_drop | output | 1 | One-cycle pulse when an incomplete frame is discarded |

## Verification
Complete frames with random contents, including random don't-care bits, check that the field positions and the MSB-first order are right. Driving the inverse data bit during each serial clock low phase separates falling-edge sampling from rising-edge sampling. Truncated frames of random length from 0 to 31 edges, each followed by a full frame, separate a clean abort from leftover shift state. Frames with extra trailing edges, and clock activity while deselected, separate the single-commit and start-on-select rules from free-running edge counting.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HELD  = 2'd2
    } rx_state_t;

    localparam int unsigned FRAME_BITS_DEF = 32;
    localparam int unsigned HDR_SKIP_DEF   = 4;
    localparam int unsigned OP_W_DEF       = 4;
    localparam int unsigned ADDR_W_DEF     = 4;
    localparam int unsigned CODE_W_DEF     = 12;

endpackage

// File: rtl/cmdrx_resync.sv
module cmdrx_resync #(
    parameter int unsigned WIDTH              = 3,
    parameter int unsigned STAGES             = 2,
    parameter logic [WIDTH-1:0] IDLE_LVL      = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{IDLE_LVL[gi]}};
            end else begin
                chain <= {chain[STAGES-2:0], pin_in[gi]};
            end
        end

        assign level[gi] = chain[STAGES-1];
    end

endmodule

// File: rtl/cmdrx_edges.sv
module cmdrx_edges (
    input  logic clk,
    input  logic rst,
    input  logic sel_lvl,
    input  logic sclk_lvl,
    output logic sel_fall,
    output logic sel_rise,
    output logic sclk_fall
);

    logic sel_prev;
    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev  <= 1'b1;
            sclk_prev <= 1'b1;
        end else begin
            sel_prev  <= sel_lvl;
            sclk_prev <= sclk_lvl;
        end
    end

    assign sel_fall  = sel_prev & ~sel_lvl;
    assign sel_rise  = ~sel_prev & sel_lvl;
    assign sclk_fall = sclk_prev & ~sclk_lvl;

endmodule

// File: rtl/cmdrx_shifter.sv
module cmdrx_shifter #(
    parameter int unsigned FRAME_BITS = 32,
    parameter int unsigned HDR_SKIP   = 4,
    parameter int unsigned FIELD_W    = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FIELD_W-1:0] fields_now,
    output logic               last_bit
);

    localparam int unsigned KEEP_W = FRAME_BITS - HDR_SKIP;
    localparam int unsigned TAIL_W = KEEP_W - FIELD_W;
    localparam int unsigned CNT_W  = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    logic [KEEP_W-2:0] shreg;
    logic [KEEP_W-1:0] word_now;
    logic [CNT_W-1:0]  bit_cnt;

    assign word_now   = {shreg, bit_in};
    assign fields_now = word_now[TAIL_W +: FIELD_W];
    assign last_bit   = (bit_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (shift_en) begin
            shreg   <= word_now[KEEP_W-2:0];
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cmdrx_fsm.sv
module cmdrx_fsm
    import cmdrx_pkg::*;
#(
    parameter int unsigned OP_W   = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CODE_W = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            sel_fall,
    input  logic                            sel_rise,
    input  logic                            sclk_fall,
    input  logic                            last_bit,
    input  logic [OP_W+ADDR_W+CODE_W-1:0]   fields_now,
    output logic                            shift_en,
    output logic                            clear,
    output logic [OP_W-1:0]                 op_q,
    output logic [ADDR_W-1:0]               addr_q,
    output logic [CODE_W-1:0]               code_q,
    output logic                            strobe_q,
    output logic                            drop_q
);

    localparam int unsigned FIELD_W = OP_W + ADDR_W + CODE_W;

    rx_state_t state, nxt;
    logic      commit;
    logic      abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt      = state;
        shift_en = 1'b0;
        clear    = 1'b0;
        commit   = 1'b0;
        abort    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sel_fall) begin
                    clear = 1'b1;
                    nxt   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sel_rise) begin
                    clear = 1'b1;
                    abort = 1'b1;
                    nxt   = ST_IDLE;
                end else if (sclk_fall) begin
                    shift_en = 1'b1;
                    if (last_bit) begin
                        commit = 1'b1;
                        nxt    = ST_HELD;
                    end
                end
            end
            ST_HELD: begin
                if (sel_rise) begin
                    nxt = ST_IDLE;
                end
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= '0;
            addr_q   <= '0;
            code_q   <= '0;
            strobe_q <= 1'b0;
            drop_q   <= 1'b0;
        end else begin
            strobe_q <= commit;
            drop_q   <= abort;
            if (commit) begin
                op_q   <= fields_now[FIELD_W-1 -: OP_W];
                addr_q <= fields_now[CODE_W +: ADDR_W];
                code_q <= fields_now[CODE_W-1:0];
            end
        end
    end

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);

    // R3
    strobe_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> $past(sclk_fall));

    // R4
    drop_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        drop_q |-> ($past(sel_rise) && !strobe_q));

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_q |-> $stable({op_q, addr_q, code_q}));

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import cmdrx_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = FRAME_BITS_DEF,
    parameter int unsigned HDR_SKIP    = HDR_SKIP_DEF,
    parameter int unsigned OP_W        = OP_W_DEF,
    parameter int unsigned ADDR_W      = ADDR_W_DEF,
    parameter int unsigned CODE_W      = CODE_W_DEF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [OP_W-1:0]   cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CODE_W-1:0] cmd_code,
    output logic              cmd_strobe,
    output logic              cmd_drop
);

    localparam int unsigned FIELD_W = OP_W + ADDR_W + CODE_W;

    logic [2:0]         pin_lvl;
    logic               sel_fall, sel_rise, sclk_fall;
    logic               shift_en, clear, last_bit;
    logic [FIELD_W-1:0] fields_now;

    cmdrx_resync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (3'b111)
    ) u_resync (
        .clk    (clk),
        .rst    (rst),
        .pin_in ({ser_dat, ser_clk, ser_sel_n}),
        .level  (pin_lvl)
    );

    cmdrx_edges u_edges (
        .clk       (clk),
        .rst       (rst),
        .sel_lvl   (pin_lvl[0]),
        .sclk_lvl  (pin_lvl[1]),
        .sel_fall  (sel_fall),
        .sel_rise  (sel_rise),
        .sclk_fall (sclk_fall)
    );

    cmdrx_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .HDR_SKIP   (HDR_SKIP),
        .FIELD_W    (FIELD_W)
    ) u_shifter (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .shift_en   (shift_en),
        .bit_in     (pin_lvl[2]),
        .fields_now (fields_now),
        .last_bit   (last_bit)
    );

    cmdrx_fsm #(
        .OP_W   (OP_W),
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sel_fall   (sel_fall),
        .sel_rise   (sel_rise),
        .sclk_fall  (sclk_fall),
        .last_bit   (last_bit),
        .fields_now (fields_now),
        .shift_en   (shift_en),
        .clear      (clear),
        .op_q       (cmd_op),
        .addr_q     (cmd_addr),
        .code_q     (cmd_code),
        .strobe_q   (cmd_strobe),
        .drop_q     (cmd_drop)
    );

endmodule

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_n, sclk, sdat;
    logic [3:0]  op, addr;
    logic [11:0] code;
    logic        strobe, drop;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int mark  = 0;
    int n_strobe = 0;
    int n_drop   = 0;
    logic [19:0] seen;
    logic [19:0] last_exp = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_cmd_rx u_dut (
        .clk        (clk),
        .rst        (rst),
        .ser_sel_n  (sel_n),
        .ser_clk    (sclk),
        .ser_dat    (sdat),
        .cmd_op     (op),
        .cmd_addr   (addr),
        .cmd_code   (code),
        .cmd_strobe (strobe),
        .cmd_drop   (drop)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] fields_of(input logic [31:0] w);
        return {w[27:24], w[23:20], w[19:8]};
    endfunction

    // monitor: counts pulses, checks R3 latency
    always @(negedge clk) begin
        if (strobe) begin
            n_strobe++;
            seen = {op, addr, code};
            check((cyc - mark) == 3, "R3 latency", cyc - mark, 3);
        end
        if (drop) n_drop++;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [31:0] w, input int nbits, input int extra);
        n_strobe = 0;
        n_drop   = 0;
        sel_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < nbits; i++) begin
            sdat = w[31-i];
            wait_cyc(4);
            sclk = 1'b0;
            if (i == 31) mark = cyc;
            wait_cyc(2);
            sdat = ~sdat;   // wrong level around rising edge (R2)
            wait_cyc(2);
            sclk = 1'b1;
        end
        for (int e = 0; e < extra; e++) begin
            sdat = 1'($urandom);
            wait_cyc(4);
            sclk = 1'b0;
            wait_cyc(4);
            sclk = 1'b1;
        end
        wait_cyc(4);
        sel_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic expect_commit(input logic [31:0] w, input string req);
        check(n_strobe == 1, {req, " R3 one strobe"}, n_strobe, 1);
        check(n_drop == 0, {req, " R6 no drop"}, n_drop, 0);
        check(seen == fields_of(w), {req, " R1 R2 fields"}, {12'h0, seen}, {12'h0, fields_of(w)});
        check({op, addr, code} == fields_of(w), {req, " R9 held"}, {12'h0, op, addr, code}, {12'h0, fields_of(w)});
        last_exp = fields_of(w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int mode;
        int len;
        void'($urandom(32'd2718));
        rst = 1'b1; sel_n = 1'b1; sclk = 1'b1; sdat = 1'b0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);
        // R8 reset state
        check({op, addr, code} == 20'h0, "R8 fields", {op, addr, code}, 0);
        check(!strobe && !drop, "R8 pulses", {strobe, drop}, 0);

        // R1 directed frame with set don't-care bits
        w = 32'hF39ABC5A;
        run_frame(w, 32, 0);
        expect_commit(w, "R1 directed");

        // R6 directed: many trailing edges
        w = 32'h0C61F0FF;
        run_frame(w, 32, 9);
        expect_commit(w, "R6 directed");

        // R4 directed: zero-edge frame
        run_frame(32'h0, 0, 0);
        check(n_drop == 1 && n_strobe == 0, "R4 empty frame", {n_drop[15:0], n_strobe[15:0]}, 32'h0001_0000);

        for (int k = 0; k < 40; k++) begin
            w = $urandom;
            mode = int'($urandom_range(0, 3));
            if (mode == 0) begin
                run_frame(w, 32, 0);
                expect_commit(w, "R1 random");
            end else if (mode == 1) begin
                run_frame(w, 32, int'($urandom_range(1, 6)));
                expect_commit(w, "R6 random");
            end else if (mode == 2) begin
                len = int'($urandom_range(0, 31));
                run_frame(w, len, 0);
                check(n_drop == 1, "R4 drop pulse", n_drop, 1);
                check(n_strobe == 0, "R4 no strobe", n_strobe, 0);
                check({op, addr, code} == last_exp, "R4 fields kept", {op, addr, code}, last_exp);
                w = $urandom;
                run_frame(w, 32, 0);
                expect_commit(w, "R5 after abort");
            end else begin
                n_strobe = 0;
                n_drop   = 0;
                for (int t = 0; t < 10; t++) begin
                    sdat = 1'($urandom);
                    wait_cyc(4);
                    sclk = ~sclk;
                end
                sclk = 1'b1;
                wait_cyc(8);
                check(n_strobe == 0 && n_drop == 0, "R7 deselected activity", {n_strobe[15:0], n_drop[15:0]}, 0);
                check({op, addr, code} == last_exp, "R7 fields kept", {op, addr, code}, last_exp);
                run_frame(w, 32, 0);
                expect_commit(w, "R7 next frame");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule